// File: doc/BRIEF.md
# Data Cache Tag Directory with Direct Software Access

This block keeps the tag and state flags of a direct-mapped data cache with 512 lines of 32 bytes. Software can look at and change any entry through a small memory-mapped port. The port takes an address, a write flag and write data, and returns read data one cycle after a read is accepted. The entry is picked by address bits 13:5.

A direct tag write can replace a line whose cached data is still modified. In that case the block first raises a write-back request. The request carries the external line address built from the old tag and the index, plus the line number in the data store. The new tag word is stored only when the external side accepts that request. Writes in the associative mode, marked by address bit 3, are ignored.

Two invalidate commands sweep the whole directory, one entry per clock. One command clears both flags of every entry. The other clears only the valid flag. A one-cycle done pulse marks the end of the sweep, and accesses are stalled while a sweep or a write-back is pending.

Top module: `dc_tag_access`

## Requirements
- R1: The entry index is `acc_addr_i[13:5]`. A read accepted on a clock edge returns that entry's word on `acc_rdata_o` with `acc_rvalid_o` high in the next cycle. The word has the tag in bits 28:10, dirty in bit 1, valid in bit 0, and zeros elsewhere.
- R2: A direct tag write stores `acc_wdata_i & 32'h1FFFFC03`. Bit 0 is the valid flag and bit 1 is the dirty flag.
- R3: A write with `acc_addr_i[3]` set changes no entry and raises no write-back.
- R4: A direct write to an entry with both flags set raises `wb_valid_o`. While the request waits, `wb_addr_o` is `{3'b000, old tag bits 28:10, index[4:0], 5'b00000}` and `wb_line_o` is the 9-bit index, and both stay stable.
- R5: While a write-back waits, `acc_busy_o` is high. The new word is stored on the edge where `wb_ready_i` is high.
- R6: A direct write to an entry without both flags set is stored on the accepting edge and raises no write-back.
- R7: A pulse on `inv_vd_i` clears bits 1 and 0 of every entry and keeps the tags.
- R8: A pulse on `inv_v_i` clears bit 0 of every entry and keeps dirty and the tags.
- R9: An invalidate sweeps one entry per cycle. From the edge that takes the command, `acc_busy_o` stays high and no access is accepted for 512 cycles. `inv_done_o` is high for exactly one cycle, 513 cycles after the command edge.
- R10: After reset every entry reads as zero, and the busy, read-valid, write-back-valid and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 14 | Access address, index in bits 13:5, associative select in bit 3 |
| acc_wdata_i | input | 32 | Tag word to write |
| acc_busy_o | output | 1 | Access is not accepted this cycle |
| acc_rvalid_o | output | 1 | Read data valid |
| acc_rdata_o | output | 32 | Read tag word |
| wb_valid_o | output | 1 | Write-back request pending |
| wb_ready_i | input | 1 | External side accepts the write-back |
| wb_addr_o | output | 32 | External address of the line to write back |
| wb_line_o | output | 9 | Data store line index for the write-back |
| inv_vd_i | input | 1 | Invalidate command clearing valid and dirty |
| inv_v_i | input | 1 | Invalidate command clearing valid only |
| inv_done_o | output | 1 | Sweep finished pulse |

## Verification
The assertions check on every cycle that:
- a pending write-back holds its address and targets an entry that is still valid and dirty;
- the stall is raised while a write-back waits;
- read data only follows an access taken in the idle state;
- the sweep index steps by one;
- the done flag lasts one cycle.

Only the bench's scenarios can show the values themselves: the masked stored word, the assembled write-back address, which flags each invalidate kind leaves behind, that associative writes leave entries unchanged, and the exact length of a sweep. The bench covers these against an independent model of the directory.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  localparam int unsigned TAG_HI = 28;
  localparam int unsigned TAG_LO = 10;
  localparam int unsigned TAG_W  = TAG_HI - TAG_LO + 1;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             dirty;
    logic             valid;
  } tag_entry_t;

  function automatic tag_entry_t pack_word(input logic [31:0] w);
    tag_entry_t e;
    e.tag   = w[TAG_HI:TAG_LO];
    e.dirty = w[1];
    e.valid = w[0];
    return e;
  endfunction

  function automatic logic [31:0] unpack_word(input tag_entry_t e);
    logic [31:0] w;
    w = '0;
    w[TAG_HI:TAG_LO] = e.tag;
    w[1] = e.dirty;
    w[0] = e.valid;
    return w;
  endfunction
endpackage

// File: rtl/tag_store.sv
module tag_store
  import tagdir_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  tag_entry_t       wdata_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output tag_entry_t       ra_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output tag_entry_t       rb_o
);
  localparam int unsigned N = 1 << IDX_W;

  tag_entry_t mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign ra_o = mem_q[ra_idx_i];
  assign rb_o = mem_q[rb_idx_i];
endmodule

// File: rtl/inv_walker.sv
module inv_walker #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             active_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic             active_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign last_o = active_q && (idx_q == {IDX_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_o;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q) begin
        idx_q <= idx_q + 1'b1;
        if (last_o) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  AST_WALK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_o) |=> (active_q && idx_q == $past(idx_q) + 1'b1)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/dc_tag_access.sv
module dc_tag_access
  import tagdir_pkg::*;
#(
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned ASSOC_BIT = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acc_valid_i,
  input  logic                   acc_write_i,
  input  logic [IDX_W+OFF_W-1:0] acc_addr_i,
  input  logic [31:0]            acc_wdata_i,
  output logic                   acc_busy_o,
  output logic                   acc_rvalid_o,
  output logic [31:0]            acc_rdata_o,
  output logic                   wb_valid_o,
  input  logic                   wb_ready_i,
  output logic [31:0]            wb_addr_o,
  output logic [IDX_W-1:0]       wb_line_o,
  input  logic                   inv_vd_i,
  input  logic                   inv_v_i,
  output logic                   inv_done_o
);
  localparam int unsigned ADDR_W = IDX_W + OFF_W;
  localparam int unsigned LOW_W  = TAG_LO - OFF_W;  // index bits inside line address
  localparam int unsigned TOP_W  = 31 - TAG_HI;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_INV} st_e;

  st_e              st_q;
  tag_entry_t       pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             clr_dirty_q;
  logic             rvalid_q;
  logic [31:0]      rdata_q;

  logic [IDX_W-1:0] acc_idx, rb_idx, widx, walk_idx;
  tag_entry_t       ra_e, rb_e, wdata, new_e;
  logic             we, inv_req, acc_fire, dwrite, needs_wb;
  logic             walk_start, walk_active, walk_last, walk_done;
  logic             unused_addr;

  assign acc_idx     = acc_addr_i[ADDR_W-1:OFF_W];
  assign unused_addr = ^acc_addr_i[OFF_W-1:0];
  assign inv_req     = inv_vd_i | inv_v_i;
  assign acc_busy_o  = (st_q != ST_IDLE) | inv_req;
  assign acc_fire    = acc_valid_i & ~acc_busy_o;
  assign dwrite      = acc_fire & acc_write_i & ~acc_addr_i[ASSOC_BIT];
  assign needs_wb    = ra_e.valid & ra_e.dirty;
  assign new_e       = pack_word(acc_wdata_i);
  assign walk_start  = (st_q == ST_IDLE) & inv_req;
  assign rb_idx      = (st_q == ST_INV) ? walk_idx : pend_idx_q;

  tag_store #(.IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .widx_i   (widx),
    .wdata_i  (wdata),
    .ra_idx_i (acc_idx),
    .ra_o     (ra_e),
    .rb_idx_i (rb_idx),
    .rb_o     (rb_e)
  );

  inv_walker #(.IDX_W(IDX_W)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (walk_start),
    .active_o (walk_active),
    .last_o   (walk_last),
    .idx_o    (walk_idx),
    .done_o   (walk_done)
  );

  always_comb begin
    we    = 1'b0;
    widx  = acc_idx;
    wdata = new_e;
    unique case (st_q)
      ST_IDLE: we = dwrite & ~needs_wb;
      ST_WB: begin
        we    = wb_ready_i;
        widx  = pend_idx_q;
        wdata = pend_q;
      end
      ST_INV: begin
        we          = walk_active;
        widx        = walk_idx;
        wdata       = rb_e;
        wdata.valid = 1'b0;
        wdata.dirty = rb_e.dirty & ~clr_dirty_q;
      end
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_q      <= '0;
      pend_idx_q  <= '0;
      clr_dirty_q <= 1'b0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rvalid_q <= acc_fire & ~acc_write_i;
      if (acc_fire && !acc_write_i) rdata_q <= unpack_word(ra_e);
      unique case (st_q)
        ST_IDLE: begin
          if (inv_req) begin
            st_q        <= ST_INV;
            clr_dirty_q <= inv_vd_i;
          end else if (dwrite && needs_wb) begin
            st_q       <= ST_WB;
            pend_q     <= new_e;
            pend_idx_q <= acc_idx;
          end
        end
        ST_WB:   if (wb_ready_i) st_q <= ST_IDLE;
        ST_INV:  if (walk_last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_rvalid_o = rvalid_q;
  assign acc_rdata_o  = rdata_q;
  assign wb_valid_o   = (st_q == ST_WB);
  assign wb_addr_o    = {{TOP_W{1'b0}}, rb_e.tag, pend_idx_q[LOW_W-1:0], {OFF_W{1'b0}}};
  assign wb_line_o    = pend_idx_q;
  assign inv_done_o   = walk_done;

  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o) && $stable(wb_line_o))); // R4
  AST_WB_OLD_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (rb_e.valid && rb_e.dirty)); // R4
  AST_WB_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> acc_busy_o); // R5
  AST_READ_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rvalid_o |-> $past(st_q == ST_IDLE && acc_valid_i && !acc_write_i)); // R9
endmodule

// File: tb/dc_tag_access_test.sv
`timescale 1ns/1ps
module dc_tag_access_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [13:0] acc_addr_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic        acc_busy_o, acc_rvalid_o;
  logic [31:0] acc_rdata_o;
  logic        wb_valid_o;
  logic        wb_ready_i = 1'b0;
  logic [31:0] wb_addr_o;
  logic [8:0]  wb_line_o;
  logic        inv_vd_i = 1'b0, inv_v_i = 1'b0;
  logic        inv_done_o;

  int checks = 0, errors = 0;
  int wb_delay = 0, wb_cnt = 0;
  logic [31:0] model [512];
  logic [31:0] rdq [$];
  logic [40:0] wbq [$];

  always #4 clk_i = ~clk_i;

  dc_tag_access uut (.*);

  task automatic chk(input bit ok, input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read monitor
  always @(negedge clk_i) begin
    if (rst_ni && acc_rvalid_o) begin
      if (rdq.size() == 0) chk(0, "R1 unexpected read", {9'd0, acc_rdata_o}, '0);
      else begin
        logic [31:0] e;
        e = rdq.pop_front();
        chk(acc_rdata_o == e, "R1/R2 read word", {9'd0, acc_rdata_o}, {9'd0, e});
      end
    end
  end

  // write-back responder and monitor
  always @(negedge clk_i) begin
    wb_ready_i <= 1'b0;
    if (rst_ni && wb_valid_o) begin
      if (!acc_busy_o) chk(0, "R5 busy during write-back", 41'd0, 41'd1);
      if (wb_cnt >= wb_delay) begin
        wb_cnt = 0;
        wb_ready_i <= 1'b1;
        if (wbq.size() == 0) chk(0, "R4 unexpected write-back", {wb_line_o, wb_addr_o}, '0);
        else begin
          logic [40:0] e;
          e = wbq.pop_front();
          chk({wb_line_o, wb_addr_o} == e, "R4 write-back addr/line", {wb_line_o, wb_addr_o}, e);
        end
      end else wb_cnt++;
    end
  end

  task automatic drive_acc(input bit wr, input logic [13:0] a, input logic [31:0] d);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_addr_i = a; acc_wdata_i = d;
    #1;
    while (acc_busy_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic do_write(input int idx, input logic [31:0] w, input bit assoc);
    logic [8:0] ix;
    ix = idx[8:0];
    if (!assoc) begin
      if (model[idx][1:0] == 2'b11)
        wbq.push_back({ix, 3'b000, model[idx][28:10], ix[4:0], 5'b00000});
      model[idx] = w & 32'h1FFFFC03;
    end
    drive_acc(1'b1, {ix, assoc ? 5'b01000 : 5'b10100}, w);
  endtask

  task automatic do_read(input int idx);
    logic [8:0] ix;
    ix = idx[8:0];
    rdq.push_back(model[idx]);
    drive_acc(1'b0, {ix, 5'b00110}, 32'hDEADBEEF);
  endtask

  task automatic do_inv(input bit both);
    int k;
    bit busy_ok, stall_ok;
    busy_ok = 1; stall_ok = 1;
    @(negedge clk_i);
    if (both) inv_vd_i = 1'b1; else inv_v_i = 1'b1;
    @(negedge clk_i);
    inv_vd_i = 1'b0; inv_v_i = 1'b0;
    k = 1;
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_addr_i = '0;
    while (!inv_done_o && k < 700) begin
      if (!acc_busy_o) busy_ok = 0;
      if (acc_rvalid_o) stall_ok = 0;
      if (k == 511) acc_valid_i = 1'b0;
      @(negedge clk_i);
      k++;
    end
    acc_valid_i = 1'b0;
    chk(busy_ok, "R9 busy during sweep", 41'd0, 41'd1);
    chk(stall_ok, "R9 no access during sweep", 41'd1, 41'd0);
    chk(k == 513, "R9 done timing", k, 41'd513);
    @(negedge clk_i);
    chk(!inv_done_o, "R9 done one cycle", {40'd0, inv_done_o}, 41'd0);
    for (int i = 0; i < 512; i++)
      model[i] = model[i] & (both ? 32'hFFFFFFFC : 32'hFFFFFFFE);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10
    chk({acc_busy_o, acc_rvalid_o, wb_valid_o, inv_done_o} == 4'b0, "R10 reset outputs",
        {37'd0, acc_busy_o, acc_rvalid_o, wb_valid_o, inv_done_o}, 41'd0);
    do_read(0);
    do_read(511);
    // R2 R6: fresh entry, no write-back
    do_write(3, 32'hFFFFFFFF, 0);
    do_read(3);
    // R1: distinct indices, offset bits ignored
    do_write(0, 32'h0000_0401, 0);
    do_write(1, 32'h1234_5678, 0);
    do_write(37, 32'hA5A5_A5A6, 0);
    do_write(300, 32'h0F0F_F003, 0);
    do_write(511, 32'h1FFF_FC01, 0);
    do_read(0); do_read(1); do_read(37); do_read(300); do_read(511); do_read(2);
    // R4 R5: write-back, immediate accept then delayed accept
    wb_delay = 0;
    do_write(3, 32'h0ABC_D401, 0);
    do_read(3);
    do_write(300, 32'h1555_5403, 0);
    wb_delay = 3;
    do_write(300, 32'h0000_0C00, 0);
    do_read(300);
    wb_delay = 0;
    // R3: associative write ignored
    do_write(37, 32'h1FFF_FC03, 1);
    do_read(37);
    do_write(511, 32'h0000_0003, 1);
    do_read(511);
    // R6: valid only / dirty only overwrite, no write-back
    do_write(1, 32'h0000_8402, 0);
    do_write(1, 32'h0000_0001, 0);
    do_read(1);
    // R8: valid-only invalidate
    do_write(10, 32'h1111_1403, 0);
    do_write(20, 32'h0222_2402, 0);
    do_inv(0);
    do_read(10); do_read(20); do_read(37); do_read(0);
    // R7: clear both flags, then overwrite produces no write-back
    do_write(50, 32'h1000_0403, 0);
    do_write(60, 32'h0300_0803, 0);
    do_inv(1);
    do_read(50); do_read(60); do_read(10);
    do_write(50, 32'h0000_0003, 0);
    do_read(50);
    repeat (4) @(negedge clk_i);
    chk(rdq.size() == 0, "R1 all reads returned", rdq.size(), 41'd0);
    chk(wbq.size() == 0, "R4 all write-backs seen", wbq.size(), 41'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule